// File: doc/BRIEF.md
# Console Register Window for a 16-bit Bus

This block gives a 16-bit processor a polled character console. It claims the top page of the address space, 0xFE00 to 0xFFFF, as I/O space and drives a select output so that the surrounding memory system keeps those accesses away from ordinary memory. Inside that page it holds four registers: a status word and a data word for the keyboard side, and a status word and a data word for the display side.

The ready flags are the handshake. A keyboard strobe latches a character and raises the keyboard flag. A bus read of the keyboard data word drops that flag. A bus write of the display data word hands a character to the display and drops the display flag. The display raises the flag again with an acknowledge once it has taken the character. Software polls bit 15 of each status word and needs no other control path.

Top module: `console_mmio`

## Requirements
- R1: `io_sel` is 1 exactly when `bus_addr[15:9]` is all ones (0xFE00 to 0xFFFF), and 0 for every lower address.
- R2: A read of 0xFE00 returns the keyboard ready flag in bit 15 and zeros in bits 14:0, in the same cycle as the read.
- R3: A `kbd_strobe` cycle stores `kbd_char` and sets the keyboard flag from the next cycle on. A read of 0xFE02 returns the stored character in bits 7:0 and zeros in bits 15:8, and clears the flag from the next cycle on.
- R4: A strobe while the keyboard flag is already set overwrites the stored character and leaves the flag set. A strobe in the same cycle as a 0xFE02 read leaves the flag set and holds the new character.
- R5: A write to 0xFE06 puts `bus_wdata[7:0]` on `disp_char` and pulses `disp_load` high for exactly the following cycle, and the display flag reads 0 from that cycle on. A read of 0xFE04 returns the display flag in bit 15 and zeros in bits 14:0. A read of 0xFE06 returns the last written character in bits 7:0 and zeros in bits 15:8.
- R6: `disp_ack` sets the display flag from the next cycle on, unless a 0xFE06 write happens in the same cycle. The write wins and the flag goes to 0.
- R7: Writes to 0xFE00, 0xFE02 and 0xFE04 change no state. The status flags, the stored keyboard character and `disp_char` keep their values.
- R8: `bus_rdata` is zero when `bus_rd` is low, when the address is outside the I/O page, and when the address is an unmapped I/O address.
- R9: After reset the keyboard flag is 0, the display flag is 1, the stored keyboard character and `disp_char` are 0, and `disp_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| io_sel | output | 1 | Address lies in I/O space, not memory |
| kbd_strobe | input | 1 | New keyboard character present |
| kbd_char | input | 8 | Keyboard character |
| disp_ack | input | 1 | Display has taken its character |
| disp_char | output | 8 | Character for the display |
| disp_load | output | 1 | One-cycle pulse: new display character |

## Verification
A wrong flag shows up on the next status read. It also shows up one cycle after the event, as a lost or duplicated handshake that a polling loop would see as a hang or a repeated character. A corrupted keyboard or display character register shows on the very next read of its data word. A decode fault shows the same cycle on `io_sel` or `bus_rdata`. The bench therefore reads the registers often, mixed randomly with strobes, acknowledges and stray writes, and compares every read against its own model.

// File: rtl/console_pkg.sv
package console_pkg;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;
  localparam int unsigned CW = 8;
  localparam int unsigned PAGE_BITS = 7;
  localparam logic [AW-1:0] KBD_STAT_A  = 16'hFE00;
  localparam logic [AW-1:0] KBD_DATA_A  = 16'hFE02;
  localparam logic [AW-1:0] DISP_STAT_A = 16'hFE04;
  localparam logic [AW-1:0] DISP_DATA_A = 16'hFE06;

  typedef struct packed {
    logic kbd_stat;
    logic kbd_data;
    logic disp_stat;
    logic disp_data;
  } reg_hit_t;

  function automatic logic in_io_page(input logic [AW-1:0] a);
    return &a[AW-1 -: PAGE_BITS];
  endfunction

  function automatic logic [DW-1:0] status_word(input logic flag);
    return {flag, {(DW-1){1'b0}}};
  endfunction

  function automatic logic [DW-1:0] data_word(input logic [CW-1:0] ch);
    return {{(DW-CW){1'b0}}, ch};
  endfunction
endpackage

// File: rtl/console_decode.sv
module console_decode
  import console_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  output logic          io_sel,
  output reg_hit_t      hit
);
  always_comb begin
    io_sel        = in_io_page(addr);
    hit.kbd_stat  = (addr == KBD_STAT_A);
    hit.kbd_data  = (addr == KBD_DATA_A);
    hit.disp_stat = (addr == DISP_STAT_A);
    hit.disp_data = (addr == DISP_DATA_A);
  end

  // R1
  hit_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> io_sel);
  // R1
  hit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/console_kbd.sv
module console_kbd
  import console_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [CW-1:0] char_in,
  input  logic          data_read,
  output logic          ready,
  output logic [CW-1:0] data
);
  logic set_ev, clr_ev;
  assign set_ev = strobe;
  assign clr_ev = data_read && !strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      data  <= '0;
    end else begin
      if (set_ev) begin
        ready <= 1'b1;
        data  <= char_in;
      end else if (clr_ev) begin
        ready <= 1'b0;
      end
    end
  end

  // R3
  kbd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ev |=> !ready);
  // R4
  kbd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (ready && data == $past(char_in)));
  // R7
  kbd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && !data_read) |=> ($stable(ready) && $stable(data)));
endmodule

// File: rtl/console_disp.sv
module console_disp
  import console_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_write,
  input  logic [CW-1:0] wchar,
  input  logic          ack,
  output logic          ready,
  output logic [CW-1:0] char_out,
  output logic          load
);
  logic take_ev, done_ev;
  assign take_ev = data_write;
  assign done_ev = ack && !data_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b1;
      char_out <= '0;
      load     <= 1'b0;
    end else begin
      load <= take_ev;
      if (take_ev) begin
        ready    <= 1'b0;
        char_out <= wchar;
      end else if (done_ev) begin
        ready <= 1'b1;
      end
    end
  end

  // R5
  disp_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ev |=> (!ready && load && char_out == $past(wchar)));
  // R6
  disp_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ev |=> ready);
  // R5
  disp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_ev |=> !load);
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [15:0]   bus_wdata,
  output logic [15:0]   bus_rdata,
  output logic          io_sel,
  input  logic          kbd_strobe,
  input  logic [7:0]    kbd_char,
  input  logic          disp_ack,
  output logic [7:0]    disp_char,
  output logic          disp_load
);
  reg_hit_t      hit;
  logic          kbd_ready, disp_ready;
  logic [CW-1:0] kbd_data;
  logic          kbd_rd_ev, disp_wr_ev;

  console_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .io_sel(io_sel), .hit(hit)
  );

  assign kbd_rd_ev  = bus_rd && hit.kbd_data;
  assign disp_wr_ev = bus_wr && hit.disp_data;

  console_kbd u_kbd (
    .clk(clk), .rst_n(rst_n), .strobe(kbd_strobe), .char_in(kbd_char),
    .data_read(kbd_rd_ev), .ready(kbd_ready), .data(kbd_data)
  );

  console_disp u_disp (
    .clk(clk), .rst_n(rst_n), .data_write(disp_wr_ev),
    .wchar(bus_wdata[CW-1:0]), .ack(disp_ack), .ready(disp_ready),
    .char_out(disp_char), .load(disp_load)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (1'b1)
        hit.kbd_stat:  bus_rdata = status_word(kbd_ready);
        hit.kbd_data:  bus_rdata = data_word(kbd_data);
        hit.disp_stat: bus_rdata = status_word(disp_ready);
        hit.disp_data: bus_rdata = data_word(disp_char);
        default:       bus_rdata = '0;
      endcase
    end
  end

  // R8
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !io_sel) |-> (bus_rdata == '0));
  // R2
  status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (hit.kbd_stat || hit.disp_stat)) |-> (bus_rdata[14:0] == '0));
endmodule

// File: tb/test_console_mmio.sv
module test_console_mmio;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 0, rst_n = 0;
  logic [15:0] bus_addr = 0, bus_wdata = 0;
  logic        bus_rd = 0, bus_wr = 0, kbd_strobe = 0, disp_ack = 0;
  logic [7:0]  kbd_char = 0;
  logic [15:0] bus_rdata;
  logic        io_sel, disp_load;
  logic [7:0]  disp_char;

  int n_chk = 0, n_bad = 0, cycles = 0;
  bit finished = 0;

  // model state
  bit       m_kr = 0, m_dr = 1, m_load = 0;
  bit [7:0] m_kd = 0, m_dc = 0;

  console_mmio i_console_mmio (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_io(input logic [15:0] a);
    return a >= 16'hFE00;
  endfunction

  function automatic logic [15:0] exp_rdata(input logic [15:0] a, input bit rd);
    if (!rd) return 16'h0;
    case (a)
      16'hFE00: return m_kr ? 16'h8000 : 16'h0;
      16'hFE02: return {8'h00, m_kd};
      16'hFE04: return m_dr ? 16'h8000 : 16'h0;
      16'hFE06: return {8'h00, m_dc};
      default:  return 16'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at negedge; check combinational outputs, then model the edge
  task automatic cyc(input logic [15:0] a, input bit rd, input bit wr,
                     input logic [15:0] wd, input bit st, input logic [7:0] ch,
                     input bit ak);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
    kbd_strobe = st; kbd_char = ch; disp_ack = ak;
    #1;
    check("R1 io_sel", {15'h0, io_sel}, {15'h0, exp_io(a)});
    if (a == 16'hFE00 || a == 16'hFE04) check("R2/R5 status read", bus_rdata, exp_rdata(a, rd));
    else if (a == 16'hFE02) check("R3 kbd data read", bus_rdata, exp_rdata(a, rd));
    else if (a == 16'hFE06) check("R5 disp data read", bus_rdata, exp_rdata(a, rd));
    else check("R8 unmapped/memory read", bus_rdata, 16'h0);
    check("R5 disp_load pulse", {15'h0, disp_load}, {15'h0, m_load});
    check("R5 disp_char", {8'h0, disp_char}, {8'h0, m_dc});
    @(posedge clk);
    if (st) begin m_kr = 1; m_kd = ch; end
    else if (rd && a == 16'hFE02) m_kr = 0;
    m_load = 0;
    if (wr && a == 16'hFE06) begin m_dr = 0; m_dc = wd[7:0]; m_load = 1; end
    else if (ak) m_dr = 1;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(16'h3000, 0, 0, 16'h0, 0, 8'h0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, MAX_CYCLES);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] picks [9];
    picks = '{16'hFE00, 16'hFE02, 16'hFE04, 16'hFE06, 16'hFE08,
              16'hFFFE, 16'hFDFF, 16'h3000, 16'h0000};
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    // R9: reset state
    check("R9 disp_load reset", {15'h0, disp_load}, 16'h0);
    check("R9 disp_char reset", {8'h0, disp_char}, 16'h0);
    rst_n = 1;
    @(negedge clk);
    cyc(16'hFE00, 1, 0, 0, 0, 0, 0);   // R9 kbd flag 0
    cyc(16'hFE04, 1, 0, 0, 0, 0, 0);   // R9 disp flag 1
    cyc(16'hFE02, 1, 0, 0, 0, 0, 0);   // R9 kbd data 0

    // R3 strobe then read clears
    cyc(16'h3000, 0, 0, 0, 1, 8'h41, 0);
    cyc(16'hFE00, 1, 0, 0, 0, 0, 0);
    cyc(16'hFE02, 1, 0, 0, 0, 0, 0);
    cyc(16'hFE00, 1, 0, 0, 0, 0, 0);
    // R4 overwrite while set, and strobe colliding with read
    cyc(16'h3000, 0, 0, 0, 1, 8'h42, 0);
    cyc(16'h3000, 0, 0, 0, 1, 8'h43, 0);
    cyc(16'hFE02, 1, 0, 0, 1, 8'h44, 0);
    cyc(16'hFE00, 1, 0, 0, 0, 0, 0);
    cyc(16'hFE02, 1, 0, 0, 0, 0, 0);
    // R7 ignored writes
    cyc(16'hFE00, 0, 1, 16'hFFFF, 0, 0, 0);
    cyc(16'hFE02, 0, 1, 16'h00AA, 0, 0, 0);
    cyc(16'hFE04, 0, 1, 16'h0000, 0, 0, 0);
    cyc(16'hFE04, 1, 0, 0, 0, 0, 0);
    cyc(16'hFE00, 1, 0, 0, 0, 0, 0);
    cyc(16'hFE02, 1, 0, 0, 0, 0, 0);
    // R5 display write, R6 ack, and write colliding with ack
    cyc(16'hFE06, 0, 1, 16'h1257, 0, 0, 0);
    cyc(16'hFE04, 1, 0, 0, 0, 0, 0);
    cyc(16'hFE06, 1, 0, 0, 0, 0, 1);
    cyc(16'hFE04, 1, 0, 0, 0, 0, 0);
    cyc(16'hFE06, 0, 1, 16'h0058, 0, 0, 1);
    cyc(16'hFE04, 1, 0, 0, 0, 0, 0);
    // R8 no read strobe, unmapped I/O, memory
    cyc(16'hFE00, 0, 0, 0, 0, 0, 0);
    cyc(16'hFE08, 1, 0, 0, 0, 0, 0);
    cyc(16'hFDFF, 1, 0, 0, 0, 0, 0);
    idle();

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      int sel = $urandom_range(0, 8);
      bit rd, wr;
      a  = (i % 7 == 3) ? 16'($urandom) : picks[sel];
      rd = $urandom_range(0, 2) != 0;
      wr = !rd && $urandom_range(0, 1) != 0;
      cyc(a, rd, wr, 16'($urandom), $urandom_range(0, 3) == 0,
          8'($urandom), $urandom_range(0, 3) == 0);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule